// File: doc/BRIEF.md
# Bridged Read Error Response Controller

This block sits on the target side of a PCI-to-system-bus bridge. When a PCI initiator's memory read has been forwarded to a slave on the system bus, the block watches how that system read ends. If the read ends abnormally, the block picks the answer the PCI target gives the initiator. That answer is one of target abort, retry, disconnect without data or disconnect with data. The block also decides what happens on the system side: terminate the transaction, flush the prefetch FIFOs or refetch automatically.

The choice depends on three things. The first is the read command type: a single memory read or a prefetching memory read multiple. The second is whether the first data phase has already finished, taken from a data-phase counter. The third is which system-bus event arrived. The events are system error, parity error, slave error or timeout, rearbitration request, burst termination and running past the valid address range. The block registers every response and drives it as a one-cycle pulse, the interrupts included. When a memory read multiple fails with a slave error, the block latches the failing address and holds it until software clears it.

Top module: `rdx_err_ctl`

## Requirements
- R1: During and directly after reset, every response pulse, every interrupt and `err_valid` are 0, and `err_addr` is 0.
- R2: A system error during a single memory read (`rd_mult`=0) gives exactly `rsp_abort`, `fifo_flush` and `irq_rd_serr` in the cycle after the event. `sys_terminate` stays 0.
- R3: A system error during a memory read multiple (`rd_mult`=1) gives exactly `rsp_abort`, `fifo_flush`, `sys_terminate` and `irq_init_serr` in the cycle after the event.
- R4: A parity error indication (`evt_perr`) on its own produces no output of any kind.
- R5: A rearbitration request while `beats_done`=0 gives `rsp_retry` for both command types.
- R6: A rearbitration request or a burst termination while `beats_done`>0 during a memory read multiple gives `sys_refetch`. The same events during a single memory read, and a burst termination while `beats_done`=0, give nothing.
- R7: A slave error during a single memory read gives `rsp_retry`. During a memory read multiple it gives `rsp_disc_nodata` and `irq_pci`, and it captures `addr_cur` into `err_addr` with `err_valid`=1 in that same output cycle.
- R8: An out-of-range address (`addr_over`) during a memory read multiple gives `rsp_disc_data`. During a single memory read it gives nothing.
- R9: When several events arrive in the same cycle, the priority is system error, then slave error, then rearbitration or burst termination, then out-of-range address. Only the winner's outputs appear, so at most one PCI response is driven.
- R10: Every response and interrupt output is high for one cycle per event and returns to 0 on the next idle cycle.
- R11: Events that arrive while `rd_active`=0 produce no output.
- R12: A captured address and `err_valid` stay unchanged until `err_clr`, even if later slave errors arrive. `err_clr` drops `err_valid` on the next cycle. If a capture and a clear arrive in the same cycle, the new address is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_active | input | 1 | A forwarded PCI read is in progress |
| rd_mult | input | 1 | 1 = memory read multiple, 0 = single memory read |
| evt_serr | input | 1 | System error on the system read |
| evt_perr | input | 1 | Parity error indication |
| evt_merr | input | 1 | Slave error or remote slave timeout |
| evt_rearb | input | 1 | Slave requests rearbitration |
| evt_bterm | input | 1 | Slave terminates the burst |
| addr_over | input | 1 | Next address lies beyond the valid range |
| beats_done | input | CNT_W | Data phases completed so far |
| addr_cur | input | ADDR_W | Address of the current system read |
| err_clr | input | 1 | Software clear of the captured error address |
| rsp_abort | output | 1 | PCI target abort |
| rsp_retry | output | 1 | PCI retry (disconnect without data on first phase) |
| rsp_disc_nodata | output | 1 | PCI disconnect without data |
| rsp_disc_data | output | 1 | PCI disconnect with data |
| fifo_flush | output | 1 | Flush the prefetch FIFOs |
| sys_terminate | output | 1 | Terminate the system transaction |
| sys_refetch | output | 1 | Reissue the system read |
| irq_rd_serr | output | 1 | Interrupt: system error on single read |
| irq_init_serr | output | 1 | Interrupt: system error on read multiple |
| irq_pci | output | 1 | Interrupt: slave error on read multiple |
| err_valid | output | 1 | `err_addr` holds a captured address |
| err_addr | output | ADDR_W | Captured failing address |

## Verification
The bench drives two and three events into the same cycle to check the priority. A design that weighed the tiers in the wrong order would emit two PCI responses, or the losing event's interrupt. The split at `beats_done`=0 is checked from both sides, so a design that refetched on the first phase, or retried after it, would show the wrong pulse. Repeated slave errors and clears that coincide with a capture are aimed at the address latch. An overwriting latch would report the newer address, and a latch that drops the capture on a same-cycle clear would leave `err_valid` low. Parity errors, inactive reads and idle cycles show whether any output leaks, or whether a pulse is stretched.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

    // Winning event class after priority resolution
    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_SERR  = 3'd1,
        EV_MERR  = 3'd2,
        EV_REARB = 3'd3,
        EV_BTERM = 3'd4,
        EV_OVER  = 3'd5
    } rdx_ev_e;

    // Registered response bundle
    typedef struct packed {
        logic abort;
        logic retry;
        logic disc_nd;
        logic disc_d;
        logic flush;
        logic sys_term;
        logic refetch;
        logic irq_rd_serr;
        logic irq_init_serr;
        logic irq_pci;
    } rdx_rsp_t;

    localparam rdx_rsp_t RSP_IDLE = '0;

endpackage

// File: rtl/rdx_classify.sv
module rdx_classify
    import rdx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             rd_active,
    input  logic             rd_mult,
    input  logic             serr,
    input  logic             perr,
    input  logic             merr,
    input  logic             rearb,
    input  logic             bterm,
    input  logic             over,
    input  logic [CNT_W-1:0] beats,
    output rdx_rsp_t         rsp,
    output logic             cap
);

    rdx_ev_e ev;
    logic    first_phase;

    assign first_phase = (beats == '0);

    // Priority: system error > slave error > rearb/bterm > address overflow
    always_comb begin
        ev = EV_NONE;
        if (!rd_active)  ev = EV_NONE;
        else if (serr)   ev = EV_SERR;
        else if (merr)   ev = EV_MERR;
        else if (rearb)  ev = EV_REARB;
        else if (bterm)  ev = EV_BTERM;
        else if (over)   ev = EV_OVER;
        else if (perr)   ev = EV_NONE;   // parity indications are ignored
    end

    always_comb begin
        rsp = RSP_IDLE;
        cap = 1'b0;
        unique case (ev)
            EV_SERR: begin
                rsp.abort = 1'b1;
                rsp.flush = 1'b1;
                if (rd_mult) begin
                    rsp.sys_term      = 1'b1;
                    rsp.irq_init_serr = 1'b1;
                end else begin
                    rsp.irq_rd_serr   = 1'b1;
                end
            end
            EV_MERR: begin
                if (rd_mult) begin
                    rsp.disc_nd = 1'b1;
                    rsp.irq_pci = 1'b1;
                    cap         = 1'b1;
                end else begin
                    rsp.retry   = 1'b1;
                end
            end
            EV_REARB: begin
                if (first_phase)  rsp.retry   = 1'b1;
                else if (rd_mult) rsp.refetch = 1'b1;
            end
            EV_BTERM: begin
                if (!first_phase && rd_mult) rsp.refetch = 1'b1;
            end
            EV_OVER: begin
                if (rd_mult) rsp.disc_d = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rdx_addr_hold.sv
module rdx_addr_hold #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              valid,
    output logic [ADDR_W-1:0] addr
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d       = hold_q;
        hold_d.valid = (hold_q.valid & ~clr) | cap;
        // first error wins until software clears
        if (cap && (!hold_q.valid || clr)) hold_d.addr = addr_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign valid = hold_q.valid;
    assign addr  = hold_q.addr;

endmodule

// File: rtl/rdx_err_ctl.sv
module rdx_err_ctl
    import rdx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_active,
    input  logic              rd_mult,
    input  logic              evt_serr,
    input  logic              evt_perr,
    input  logic              evt_merr,
    input  logic              evt_rearb,
    input  logic              evt_bterm,
    input  logic              addr_over,
    input  logic [CNT_W-1:0]  beats_done,
    input  logic [ADDR_W-1:0] addr_cur,
    input  logic              err_clr,
    output logic              rsp_abort,
    output logic              rsp_retry,
    output logic              rsp_disc_nodata,
    output logic              rsp_disc_data,
    output logic              fifo_flush,
    output logic              sys_terminate,
    output logic              sys_refetch,
    output logic              irq_rd_serr,
    output logic              irq_init_serr,
    output logic              irq_pci,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr
);

    rdx_rsp_t rsp_d, rsp_q;
    logic     cap;

    rdx_classify #(.CNT_W(CNT_W)) u_cls (
        .rd_active (rd_active),
        .rd_mult   (rd_mult),
        .serr      (evt_serr),
        .perr      (evt_perr),
        .merr      (evt_merr),
        .rearb     (evt_rearb),
        .bterm     (evt_bterm),
        .over      (addr_over),
        .beats     (beats_done),
        .rsp       (rsp_d),
        .cap       (cap)
    );

    rdx_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap),
        .clr     (err_clr),
        .addr_in (addr_cur),
        .valid   (err_valid),
        .addr    (err_addr)
    );

    // Registered single-cycle pulses: each cycle reflects only that cycle's event
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= RSP_IDLE;
        else        rsp_q <= rsp_d;
    end

    assign rsp_abort       = rsp_q.abort;
    assign rsp_retry       = rsp_q.retry;
    assign rsp_disc_nodata = rsp_q.disc_nd;
    assign rsp_disc_data   = rsp_q.disc_d;
    assign fifo_flush      = rsp_q.flush;
    assign sys_terminate   = rsp_q.sys_term;
    assign sys_refetch     = rsp_q.refetch;
    assign irq_rd_serr     = rsp_q.irq_rd_serr;
    assign irq_init_serr   = rsp_q.irq_init_serr;
    assign irq_pci         = rsp_q.irq_pci;

endmodule

// File: rtl/rdx_err_chk.sv
module rdx_err_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_active,
    input logic              evt_serr,
    input logic              evt_perr,
    input logic              evt_merr,
    input logic              evt_rearb,
    input logic              evt_bterm,
    input logic              addr_over,
    input logic              err_clr,
    input logic              rsp_abort,
    input logic              rsp_retry,
    input logic              rsp_disc_nodata,
    input logic              rsp_disc_data,
    input logic              fifo_flush,
    input logic              sys_terminate,
    input logic              sys_refetch,
    input logic              irq_rd_serr,
    input logic              irq_init_serr,
    input logic              irq_pci,
    input logic              err_valid,
    input logic [ADDR_W-1:0] err_addr
);

    logic any_out;
    assign any_out = rsp_abort | rsp_retry | rsp_disc_nodata | rsp_disc_data |
                     fifo_flush | sys_terminate | sys_refetch |
                     irq_rd_serr | irq_init_serr | irq_pci;

    a_r2_abort_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> fifo_flush);

    a_r3_term_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        sys_terminate |-> (irq_init_serr && !irq_rd_serr));

    a_r9_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_abort, rsp_retry, rsp_disc_nodata, rsp_disc_data, sys_refetch}));

    a_r11_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |=> !any_out);

    a_r4_perr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_perr && !evt_serr && !evt_merr && !evt_rearb && !evt_bterm && !addr_over)
        |=> !any_out);

    a_r12_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !err_clr) |=> (err_valid && $stable(err_addr)));

    a_r7_irq_captures: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pci |-> err_valid);

endmodule

bind rdx_err_ctl rdx_err_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_rdx_err_ctl.sv
module sim_rdx_err_ctl;

    localparam int AW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_active = 1'b0, rd_mult = 1'b0;
    logic          evt_serr = 1'b0, evt_perr = 1'b0, evt_merr = 1'b0;
    logic          evt_rearb = 1'b0, evt_bterm = 1'b0, addr_over = 1'b0;
    logic [CW-1:0] beats_done = '0;
    logic [AW-1:0] addr_cur = '0;
    logic          err_clr = 1'b0;
    logic          rsp_abort, rsp_retry, rsp_disc_nodata, rsp_disc_data;
    logic          fifo_flush, sys_terminate, sys_refetch;
    logic          irq_rd_serr, irq_init_serr, irq_pci, err_valid;
    logic [AW-1:0] err_addr;

    always #2 clk = ~clk;   // 250 MHz

    rdx_err_ctl #(.ADDR_W(AW), .CNT_W(CW)) u0 (.*);

    // expected vector bits: abort retry discnd discd flush term refetch irqrd irqinit irqpci valid
    localparam logic [10:0] X_ABORT = 11'b10000000000;
    localparam logic [10:0] X_RETRY = 11'b01000000000;
    localparam logic [10:0] X_DND   = 11'b00100000000;
    localparam logic [10:0] X_DD    = 11'b00010000000;
    localparam logic [10:0] X_FLUSH = 11'b00001000000;
    localparam logic [10:0] X_TERM  = 11'b00000100000;
    localparam logic [10:0] X_REF   = 11'b00000010000;
    localparam logic [10:0] X_IRD   = 11'b00000001000;
    localparam logic [10:0] X_IINIT = 11'b00000000100;
    localparam logic [10:0] X_IPCI  = 11'b00000000010;
    localparam logic [10:0] X_VAL   = 11'b00000000001;

    // event bits: [4] serr [3] perr [2] merr [1] rearb [0] bterm
    localparam logic [4:0] E_SERR = 5'b10000, E_PERR = 5'b01000, E_MERR = 5'b00100;
    localparam logic [4:0] E_REARB = 5'b00010, E_BTERM = 5'b00001, E_NONE = 5'b00000;

    logic [10:0]   exp_q[$];
    logic [AW-1:0] ea_q[$];
    string         tag_q[$];
    int            checks = 0;
    int            fails  = 0;
    logic          done   = 1'b0;

    function automatic logic [10:0] got_vec();
        return {rsp_abort, rsp_retry, rsp_disc_nodata, rsp_disc_data, fifo_flush,
                sys_terminate, sys_refetch, irq_rd_serr, irq_init_serr, irq_pci, err_valid};
    endfunction

    // driver: one stimulus cycle, expected result pushed to the scoreboard
    task automatic drive(input logic act, input logic m, input logic [4:0] ev,
                         input logic over, input logic [CW-1:0] beats,
                         input logic [AW-1:0] addr, input logic clr,
                         input logic [10:0] ex, input logic [AW-1:0] ea, input string tag);
        @(negedge clk);
        rd_active  = act;       rd_mult   = m;
        evt_serr   = ev[4];     evt_perr  = ev[3];  evt_merr = ev[2];
        evt_rearb  = ev[1];     evt_bterm = ev[0];  addr_over = over;
        beats_done = beats;     addr_cur  = addr;   err_clr  = clr;
        exp_q.push_back(ex);
        ea_q.push_back(ea);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic [10:0] ex, input logic [AW-1:0] ea, input string tag);
        drive(1'b0, 1'b0, E_NONE, 1'b0, '0, '0, 1'b0, ex, ea, tag);
    endtask

    // monitor: compare shortly after the edge that registers each stimulus
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() > 0) begin
                logic [10:0]   ex;
                logic [AW-1:0] ea;
                string         tg;
                ex = exp_q.pop_front();
                ea = ea_q.pop_front();
                tg = tag_q.pop_front();
                #1;
                checks++;
                if (got_vec() !== ex || (ex[0] && err_addr !== ea)) begin
                    fails++;
                    $display("FAIL %s: got vec=%b addr=%h expected vec=%b addr=%h",
                             tg, got_vec(), err_addr, ex, ea);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 during reset
        if (got_vec() !== 11'b0 || err_addr !== '0) begin
            fails++;
            $display("FAIL R1: got vec=%b addr=%h expected vec=0 addr=0", got_vec(), err_addr);
        end
        rst_n = 1'b1;
        idle(11'b0, '0, "R1 after reset");

        // R2 / R3 system error
        drive(1, 0, E_SERR, 0, 8'd0, 32'h100, 0, X_ABORT|X_FLUSH|X_IRD, '0, "R2 serr single");
        idle(11'b0, '0, "R10 pulse ends");
        drive(1, 1, E_SERR, 0, 8'd4, 32'h104, 0, X_ABORT|X_FLUSH|X_TERM|X_IINIT, '0, "R3 serr multiple");
        idle(11'b0, '0, "R10 pulse ends");

        // R4 parity ignored
        drive(1, 0, E_PERR, 0, 8'd0, 32'h10, 0, 11'b0, '0, "R4 perr single");
        drive(1, 1, E_PERR, 0, 8'd2, 32'h14, 0, 11'b0, '0, "R4 perr multiple");

        // R5 rearb on first phase
        drive(1, 0, E_REARB, 0, 8'd0, 32'h20, 0, X_RETRY, '0, "R5 rearb first single");
        drive(1, 1, E_REARB, 0, 8'd0, 32'h24, 0, X_RETRY, '0, "R5 rearb first multiple");

        // R6 refetch after first phase
        drive(1, 1, E_REARB, 0, 8'd3, 32'h28, 0, X_REF, '0, "R6 rearb later multiple");
        drive(1, 1, E_BTERM, 0, 8'd1, 32'h2C, 0, X_REF, '0, "R6 bterm later multiple");
        drive(1, 0, E_REARB, 0, 8'd1, 32'h30, 0, 11'b0, '0, "R6 rearb later single");
        drive(1, 1, E_BTERM, 0, 8'd0, 32'h34, 0, 11'b0, '0, "R6 bterm first multiple");

        // R8 address overflow
        drive(1, 1, E_NONE, 1, 8'd7, 32'h3C, 0, X_DD, '0, "R8 overflow multiple");
        drive(1, 0, E_NONE, 1, 8'd0, 32'h3C, 0, 11'b0, '0, "R8 overflow single");

        // R7 slave error
        drive(1, 0, E_MERR, 0, 8'd0, 32'h40, 0, X_RETRY, '0, "R7 merr single");
        drive(1, 1, E_MERR, 0, 8'd2, 32'hA000_0040, 0, X_DND|X_IPCI|X_VAL, 32'hA000_0040, "R7 merr multiple");
        idle(X_VAL, 32'hA000_0040, "R12 held idle");
        drive(1, 1, E_MERR, 0, 8'd5, 32'hB000_0080, 0, X_DND|X_IPCI|X_VAL, 32'hA000_0040, "R12 no overwrite");
        drive(0, 0, E_NONE, 0, '0, '0, 1, 11'b0, '0, "R12 clear");
        drive(1, 1, E_MERR, 0, 8'd1, 32'hC000_00C0, 0, X_DND|X_IPCI|X_VAL, 32'hC000_00C0, "R12 recapture");
        drive(1, 1, E_MERR, 0, 8'd1, 32'hD000_00D0, 1, X_DND|X_IPCI|X_VAL, 32'hD000_00D0, "R12 capture with clear");
        drive(0, 0, E_NONE, 0, '0, '0, 1, 11'b0, '0, "R12 clear again");

        // R9 priority
        drive(1, 1, E_SERR|E_MERR|E_REARB, 1, 8'd0, 32'h50, 0, X_ABORT|X_FLUSH|X_TERM|X_IINIT, '0, "R9 serr wins");
        drive(1, 1, E_MERR|E_REARB, 0, 8'd0, 32'hE000_0060, 0, X_DND|X_IPCI|X_VAL, 32'hE000_0060, "R9 merr over rearb");
        drive(0, 0, E_NONE, 0, '0, '0, 1, 11'b0, '0, "R12 clear");
        drive(1, 1, E_REARB, 1, 8'd4, 32'h70, 0, X_REF, '0, "R9 rearb over overflow");
        drive(1, 0, E_MERR|E_REARB, 0, 8'd0, 32'h74, 0, X_RETRY, '0, "R9 merr single over rearb");

        // R11 inactive read
        drive(0, 1, E_SERR|E_MERR|E_REARB, 1, 8'd2, 32'h80, 0, 11'b0, '0, "R11 inactive");
        idle(11'b0, '0, "R10 final idle");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule